// File: doc/BRIEF.md
# Dual-Port RAM Register Bank with Shared-Port Arbitration

This block keeps a bank of 32-bit registers in a dual-port RAM instead of flip-flops. One RAM port belongs to the fabric and only reads. The fabric gives a word address, and the word stored there appears one clock later. The other RAM port is shared by three requesters: fabric writes, bus writes and bus reads. A fixed-priority arbiter picks one of them each cycle.

The bus side is a subordinate with ready/valid handshakes. It has a combined write request channel (address and data together), a write response channel, a read request channel and a read response channel. Each channel keeps at most one transaction outstanding. Byte addresses are decoded into word indices. Any address that falls outside the bank is answered with a decode error, and the RAM is not touched.

Because the storage is a RAM, the fabric sees one register per access, not every register at once. The fabric read port never waits on other traffic.

Top module: `regbank_dpram_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `s_b_valid` and `s_r_valid` are low.
- R2: `fab_rd_data` shows the word at the `fab_rd_addr` sampled at the previous rising edge. This one-cycle latency holds whatever the bus is doing.
- R3: When `fab_we` is high at a rising edge, `fab_wr_data` is stored at `fab_wr_addr`. This happens every cycle, whatever the bus requests.
- R4: The shared port is granted by fixed priority: fabric write, then bus write, then bus read. An in-range bus request that loses keeps its ready low. It is accepted in the first cycle in which no higher-priority requester is active.
- R5: A bus byte address selects word index `addr[ADDR_W+1:2]`. Address bits 1:0 are ignored.
- R6: After a write handshake, `s_b_valid` is high in the next cycle and stays high until `s_b_ready`. An in-range write answers OKAY (`2'b00`).
- R7: After a read handshake, `s_r_valid` is high in the next cycle, with OKAY (`2'b00`) and the word the RAM held at the grant edge. `s_r_data` stays unchanged until `s_r_ready`, even if that word is rewritten in the meantime.
- R8: A bus address with any bit set above bit `ADDR_W+1` is accepted without waiting for the shared port and answered with DECERR (`2'b11`). Such a write changes no word. Such a read returns zero data.
- R9: If the fabric reads the word that is written in the same cycle, the fabric read returns the old contents. The new contents appear on the next read.
- R10: While `s_b_valid` is high, `s_wr_ready` is low. While `s_r_valid` is high, `s_ar_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fab_rd_addr | input | ADDR_W | Fabric read word index |
| fab_rd_data | output | DATA_W | Fabric read data, one cycle latency |
| fab_we | input | 1 | Fabric write enable (highest priority) |
| fab_wr_addr | input | ADDR_W | Fabric write word index |
| fab_wr_data | input | DATA_W | Fabric write data |
| s_wr_valid | input | 1 | Bus write request valid |
| s_wr_ready | output | 1 | Bus write request accepted |
| s_wr_addr | input | BUS_AW | Bus write byte address |
| s_wr_data | input | DATA_W | Bus write data |
| s_b_valid | output | 1 | Write response valid |
| s_b_ready | input | 1 | Write response taken |
| s_b_resp | output | 2 | Write response code |
| s_ar_valid | input | 1 | Bus read request valid |
| s_ar_ready | output | 1 | Bus read request accepted |
| s_ar_addr | input | BUS_AW | Bus read byte address |
| s_r_valid | output | 1 | Read response valid |
| s_r_ready | input | 1 | Read response taken |
| s_r_data | output | DATA_W | Read response data |
| s_r_resp | output | 2 | Read response code |

## Verification
The bench builds the block with `ADDR_W = 4` and `BUS_AW = 8`. That gives a 16-word bank, so every word can be written and read back through each path. Three quarters of the bus address space then lies outside the bank, and several of those addresses alias onto real word indices through their low bits, which shows whether the decode error really leaves the RAM alone. The small size also leaves room to set up each priority conflict, the same-address collision and the held responses cycle by cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_DECERR = 2'b11;

   // shared-port requester positions, lower index wins
   localparam int REQ_FAB_WR = 0;
   localparam int REQ_BUS_WR = 1;
   localparam int REQ_BUS_RD = 2;
   localparam int REQ_COUNT  = 3;
endpackage

// File: rtl/regbank_ram.sv
module regbank_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] a_addr,
   output logic [DATA_W-1:0] a_q,
   input  logic              b_we,
   input  logic              b_re,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wd,
   output logic [DATA_W-1:0] b_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // non-blocking update gives read-old-data on an address collision
   always_ff @(posedge clk) begin
      a_q <= mem[a_addr];
      if (b_we) mem[b_addr] <= b_wd;
      if (b_re) b_q <= mem[b_addr];
   end
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode #(
   parameter int ADDR_W = 10,
   parameter int BUS_AW = 32
) (
   input  logic [BUS_AW-1:0] byte_addr,
   output logic              hit,
   output logic [ADDR_W-1:0] word_idx
);
   localparam int TOP_LSB = ADDR_W + 2;

   logic unused_lsb;
   assign unused_lsb = ^byte_addr[1:0];
   assign word_idx   = byte_addr[TOP_LSB-1:2];

   generate
      if (BUS_AW == TOP_LSB) begin : g_full
         assign hit = 1'b1;
      end else begin : g_window
         assign hit = ~|byte_addr[BUS_AW-1:TOP_LSB];
      end
   endgenerate
endmodule

// File: rtl/regbank_arb.sv
module regbank_arb #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_slot
         if (i == 0) begin : g_top
            assign gnt[i] = req[i];
         end else begin : g_lower
            assign gnt[i] = req[i] & ~|req[i-1:0];
         end
      end
   endgenerate

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R4
   AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0); // R4
   AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> gnt[0]); // R3
endmodule

// File: rtl/regbank_hold.sv
module regbank_hold #(
   parameter int PW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] pay_in,
   input  logic          take,
   output logic          valid,
   output logic [PW-1:0] pay
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         pay   <= '0;
      end else if (load) begin
         valid <= 1'b1;
         pay   <= pay_in;
      end else if (take) begin
         valid <= 1'b0;
      end
   end

   AST_NO_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> !load); // R10
endmodule

// File: rtl/regbank_dpram_arb.sv
module regbank_dpram_arb
   import regbank_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int BUS_AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fab_rd_addr,
   output logic [DATA_W-1:0] fab_rd_data,
   input  logic              fab_we,
   input  logic [ADDR_W-1:0] fab_wr_addr,
   input  logic [DATA_W-1:0] fab_wr_data,
   input  logic              s_wr_valid,
   output logic              s_wr_ready,
   input  logic [BUS_AW-1:0] s_wr_addr,
   input  logic [DATA_W-1:0] s_wr_data,
   output logic              s_b_valid,
   input  logic              s_b_ready,
   output logic [1:0]        s_b_resp,
   input  logic              s_ar_valid,
   output logic              s_ar_ready,
   input  logic [BUS_AW-1:0] s_ar_addr,
   output logic              s_r_valid,
   input  logic              s_r_ready,
   output logic [DATA_W-1:0] s_r_data,
   output logic [1:0]        s_r_resp
);
   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_depth
         $error("regbank_dpram_arb: ADDR_W must be 1..10");
      end
      if (DATA_W != 32) begin : g_bad_width
         $error("regbank_dpram_arb: DATA_W must be 32");
      end
      if (BUS_AW < ADDR_W + 2) begin : g_bad_bus
         $error("regbank_dpram_arb: BUS_AW too narrow for the bank");
      end
   endgenerate

   logic              w_hit, r_hit;
   logic [ADDR_W-1:0] w_idx, r_idx;
   logic [REQ_COUNT-1:0] req, gnt;
   logic              wr_acc, ar_acc;
   logic              b_we, b_re;
   logic [ADDR_W-1:0] b_addr;
   logic [DATA_W-1:0] b_wd, b_q;
   logic [0:0]        r_err;

   regbank_decode #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) wr_dec_i (
      .byte_addr(s_wr_addr), .hit(w_hit), .word_idx(w_idx));
   regbank_decode #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) rd_dec_i (
      .byte_addr(s_ar_addr), .hit(r_hit), .word_idx(r_idx));

   assign req[REQ_FAB_WR] = fab_we;
   assign req[REQ_BUS_WR] = s_wr_valid & w_hit & ~s_b_valid;
   assign req[REQ_BUS_RD] = s_ar_valid & r_hit & ~s_r_valid;

   regbank_arb #(.N(REQ_COUNT)) arb_i (
      .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt));

   // out-of-range requests need no RAM slot and are taken at once
   assign s_wr_ready = ~s_b_valid & (w_hit ? gnt[REQ_BUS_WR] : 1'b1);
   assign s_ar_ready = ~s_r_valid & (r_hit ? gnt[REQ_BUS_RD] : 1'b1);
   assign wr_acc     = s_wr_valid & s_wr_ready;
   assign ar_acc     = s_ar_valid & s_ar_ready;

   assign b_we = gnt[REQ_FAB_WR] | gnt[REQ_BUS_WR];
   assign b_re = gnt[REQ_BUS_RD];

   always_comb begin
      if (gnt[REQ_FAB_WR]) begin
         b_addr = fab_wr_addr;
         b_wd   = fab_wr_data;
      end else if (gnt[REQ_BUS_WR]) begin
         b_addr = w_idx;
         b_wd   = s_wr_data;
      end else begin
         b_addr = r_idx;
         b_wd   = s_wr_data;
      end
   end

   regbank_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
      .clk(clk), .a_addr(fab_rd_addr), .a_q(fab_rd_data),
      .b_we(b_we), .b_re(b_re), .b_addr(b_addr), .b_wd(b_wd), .b_q(b_q));

   regbank_hold #(.PW(2)) bresp_i (
      .clk(clk), .rst_n(rst_n), .load(wr_acc),
      .pay_in(w_hit ? RESP_OKAY : RESP_DECERR),
      .take(s_b_ready), .valid(s_b_valid), .pay(s_b_resp));

   regbank_hold #(.PW(1)) rresp_i (
      .clk(clk), .rst_n(rst_n), .load(ar_acc), .pay_in(~r_hit),
      .take(s_r_ready), .valid(s_r_valid), .pay(r_err));

   assign s_r_resp = r_err[0] ? RESP_DECERR : RESP_OKAY;
   assign s_r_data = r_err[0] ? '0 : b_q;

   AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (fab_we && s_wr_valid && w_hit) |-> !s_wr_ready); // R4
   AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ar_valid && r_hit && (fab_we || (s_wr_valid && s_wr_ready && w_hit))) |-> !s_ar_ready); // R4
   AST_B_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> s_b_valid); // R6
   AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_b_valid && !s_b_ready) |=> (s_b_valid && $stable(s_b_resp))); // R6
   AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_r_valid && !s_r_ready) |=> (s_r_valid && $stable(s_r_data))); // R7
   AST_DECERR_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_acc && !r_hit) |=> (s_r_valid && s_r_resp == RESP_DECERR && s_r_data == '0)); // R8
   AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_b_valid && s_wr_ready) && !(s_r_valid && s_ar_ready)); // R10
endmodule

// File: tb/regbank_dpram_arb_tb.sv
module regbank_dpram_arb_tb_top;
   localparam int AW  = 4;
   localparam int BAW = 8;
   localparam int DW  = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n;
   logic [AW-1:0]  fab_rd_addr, fab_wr_addr;
   logic [DW-1:0]  fab_rd_data, fab_wr_data;
   logic           fab_we;
   logic           s_wr_valid, s_wr_ready, s_b_valid, s_b_ready;
   logic [BAW-1:0] s_wr_addr, s_ar_addr;
   logic [DW-1:0]  s_wr_data, s_r_data;
   logic [1:0]     s_b_resp, s_r_resp;
   logic           s_ar_valid, s_ar_ready, s_r_valid, s_r_ready;

   regbank_dpram_arb #(.ADDR_W(AW), .DATA_W(DW), .BUS_AW(BAW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .fab_rd_addr(fab_rd_addr), .fab_rd_data(fab_rd_data),
      .fab_we(fab_we), .fab_wr_addr(fab_wr_addr), .fab_wr_data(fab_wr_data),
      .s_wr_valid(s_wr_valid), .s_wr_ready(s_wr_ready), .s_wr_addr(s_wr_addr),
      .s_wr_data(s_wr_data), .s_b_valid(s_b_valid), .s_b_ready(s_b_ready),
      .s_b_resp(s_b_resp), .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready),
      .s_ar_addr(s_ar_addr), .s_r_valid(s_r_valid), .s_r_ready(s_r_ready),
      .s_r_data(s_r_data), .s_r_resp(s_r_resp));

   int n_chk  = 0;
   int n_fail = 0;
   logic [DW-1:0] model [16];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] wval(input int i);
      return 32'h1000_0000 + i * 32'h0001_0203;
   endfunction

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] er, input string tag);
      bit hs = 1'b0;
      s_wr_valid = 1'b1; s_wr_addr = a; s_wr_data = d; s_b_ready = 1'b1;
      while (!hs) begin
         #1;
         hs = s_wr_ready;
         tick;
      end
      s_wr_valid = 1'b0;
      chk(s_b_valid === 1'b1 && s_b_resp === er, tag, {31'b0, s_b_valid, s_b_resp}, {31'b0, 1'b1, er});
      if (er == 2'b00) model[a[5:2]] = d;
      tick;
      chk(s_b_valid === 1'b0, "R6 bvalid drop", {31'b0, s_b_valid}, 32'd0);
   endtask

   task automatic bus_rd(input logic [7:0] a, input logic [31:0] ed, input logic [1:0] er, input string tag);
      bit hs = 1'b0;
      s_ar_valid = 1'b1; s_ar_addr = a; s_r_ready = 1'b1;
      while (!hs) begin
         #1;
         hs = s_ar_ready;
         tick;
      end
      s_ar_valid = 1'b0;
      chk(s_r_valid === 1'b1 && s_r_resp === er && s_r_data === ed, tag, s_r_data, ed);
      tick;
   endtask

   task automatic fab_chk(input int idx, input string tag);
      fab_rd_addr = AW'(idx);
      tick;
      chk(fab_rd_data === model[idx], tag, fab_rd_data, model[idx]);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; fab_we = 1'b0; fab_rd_addr = '0; fab_wr_addr = '0; fab_wr_data = '0;
      s_wr_valid = 1'b0; s_wr_addr = '0; s_wr_data = '0; s_b_ready = 1'b1;
      s_ar_valid = 1'b0; s_ar_addr = '0; s_r_ready = 1'b1;
      repeat (3) tick;
      chk(s_b_valid === 1'b0 && s_r_valid === 1'b0, "R1 in reset", {30'b0, s_b_valid, s_r_valid}, 32'd0);
      rst_n = 1'b1;
      tick;
      chk(s_b_valid === 1'b0 && s_r_valid === 1'b0, "R1 after reset", {30'b0, s_b_valid, s_r_valid}, 32'd0);

      // R6 / R5: fill every word over the bus
      for (int i = 0; i < 16; i++) bus_wr(8'(i * 4), wval(i), 2'b00, "R6 write okay");
      // R2: fabric read-back of all words
      for (int i = 0; i < 16; i++) fab_chk(i, "R2 fabric read");
      // R7: bus read-back of all words
      for (int i = 0; i < 16; i++) bus_rd(8'(i * 4), model[i], 2'b00, "R7 bus read");

      // R3: fabric writes over every word, checked through the bus
      for (int i = 0; i < 16; i++) begin
         fab_we = 1'b1; fab_wr_addr = AW'(i); fab_wr_data = ~wval(i);
         tick;
         model[i] = ~wval(i);
      end
      fab_we = 1'b0;
      for (int i = 0; i < 16; i++) bus_rd(8'(i * 4 + (i % 4)), model[i], 2'b00, "R3 fabric write seen");

      // R5: low address bits ignored
      bus_wr(8'h17, 32'hCAFE_0005, 2'b00, "R5 write low bits");
      bus_rd(8'h16, 32'hCAFE_0005, 2'b00, "R5 read low bits");

      // R8: out-of-range accesses aliasing onto real indices
      for (int k = 1; k < 4; k++) begin
         bus_wr(8'(k * 64 + 8), 32'hDEAD_0000 + k, 2'b11, "R8 write decerr");
         bus_rd(8'(k * 64 + 8), 32'h0, 2'b11, "R8 read decerr");
      end
      fab_chk(2, "R8 word untouched");

      // R4: bus write stalls behind fabric write
      fab_we = 1'b1; fab_wr_addr = 4'd2; fab_wr_data = 32'h2222_AAAA;
      s_wr_valid = 1'b1; s_wr_addr = 8'h0C; s_wr_data = 32'h3333_BBBB; s_b_ready = 1'b1;
      for (int c = 0; c < 3; c++) begin
         #1;
         chk(s_wr_ready === 1'b0, "R4 write waits", {31'b0, s_wr_ready}, 32'd0);
         tick;
      end
      fab_we = 1'b0; model[2] = 32'h2222_AAAA;
      #1;
      chk(s_wr_ready === 1'b1, "R4 write taken when free", {31'b0, s_wr_ready}, 32'd1);
      tick;
      s_wr_valid = 1'b0; model[3] = 32'h3333_BBBB;
      chk(s_b_valid === 1'b1 && s_b_resp === 2'b00, "R6 after stall", {30'b0, s_b_resp}, 32'd0);
      tick;
      fab_chk(2, "R3 stalled cycle write");
      fab_chk(3, "R4 stalled write landed");

      // R8: out-of-range write accepted during a fabric write
      fab_we = 1'b1; fab_wr_addr = 4'd0; fab_wr_data = 32'h0F0F_0F0F;
      s_wr_valid = 1'b1; s_wr_addr = 8'h80; s_wr_data = 32'hBAD0_BAD0;
      #1;
      chk(s_wr_ready === 1'b1, "R8 no port wait", {31'b0, s_wr_ready}, 32'd1);
      tick;
      fab_we = 1'b0; s_wr_valid = 1'b0; model[0] = 32'h0F0F_0F0F;
      chk(s_b_valid === 1'b1 && s_b_resp === 2'b11, "R8 decerr during fab write", {30'b0, s_b_resp}, 32'd3);
      tick;
      fab_chk(0, "R8 alias not written");

      // R4: bus read loses to bus write and to fabric write
      fab_we = 1'b1; fab_wr_addr = 4'd9; fab_wr_data = 32'h9999_0000;
      s_ar_valid = 1'b1; s_ar_addr = 8'h24; s_r_ready = 1'b1;
      #1;
      chk(s_ar_ready === 1'b0, "R4 read behind fabric write", {31'b0, s_ar_ready}, 32'd0);
      tick;
      fab_we = 1'b0; model[9] = 32'h9999_0000;
      s_wr_valid = 1'b1; s_wr_addr = 8'h24; s_wr_data = 32'h9999_1111;
      fab_rd_addr = 4'd9;
      #1;
      chk(s_wr_ready === 1'b1 && s_ar_ready === 1'b0, "R4 read behind bus write",
          {30'b0, s_wr_ready, s_ar_ready}, 32'd2);
      tick;
      chk(fab_rd_data === 32'h9999_0000, "R9 old data on bus collision", fab_rd_data, 32'h9999_0000);
      s_wr_valid = 1'b0; model[9] = 32'h9999_1111;
      #1;
      chk(s_ar_ready === 1'b1, "R4 read taken when free", {31'b0, s_ar_ready}, 32'd1);
      tick;
      s_ar_valid = 1'b0;
      chk(s_r_valid === 1'b1 && s_r_data === 32'h9999_1111, "R7 read after write", s_r_data, 32'h9999_1111);
      chk(fab_rd_data === 32'h9999_1111, "R2 during bus read", fab_rd_data, 32'h9999_1111);
      tick;

      // R9: fabric read and write to the same word
      fab_rd_addr = 4'd7; fab_we = 1'b1; fab_wr_addr = 4'd7; fab_wr_data = 32'h7777_7777;
      tick;
      fab_we = 1'b0;
      chk(fab_rd_data === model[7], "R9 old data", fab_rd_data, model[7]);
      model[7] = 32'h7777_7777;
      tick;
      chk(fab_rd_data === model[7], "R9 new data next", fab_rd_data, model[7]);

      // R7 / R10: held read response while the word is rewritten
      s_r_ready = 1'b0; s_ar_valid = 1'b1; s_ar_addr = 8'h2C;
      tick;
      s_ar_valid = 1'b0;
      chk(s_r_valid === 1'b1 && s_r_data === model[11], "R7 read data", s_r_data, model[11]);
      s_wr_valid = 1'b1; s_wr_addr = 8'h2C; s_wr_data = 32'hB0B0_B0B0;
      s_ar_valid = 1'b1; s_ar_addr = 8'h30;
      #1;
      chk(s_ar_ready === 1'b0, "R10 read blocked while pending", {31'b0, s_ar_ready}, 32'd0);
      tick;
      s_wr_valid = 1'b0; s_ar_valid = 1'b0;
      chk(s_r_valid === 1'b1 && s_r_data === model[11], "R7 held after rewrite", s_r_data, model[11]);
      model[11] = 32'hB0B0_B0B0;
      tick;
      chk(s_r_valid === 1'b1 && s_r_data !== model[11], "R7 still held", s_r_data, model[11]);
      s_r_ready = 1'b1;
      tick;
      chk(s_r_valid === 1'b0, "R7 released", {31'b0, s_r_valid}, 32'd0);

      // R6 / R10: held write response blocks a new write
      s_b_ready = 1'b0;
      s_wr_valid = 1'b1; s_wr_addr = 8'h10; s_wr_data = 32'h4444_0001;
      tick;
      model[4] = 32'h4444_0001;
      s_wr_addr = 8'h14; s_wr_data = 32'h5555_0002;
      for (int c = 0; c < 2; c++) begin
         #1;
         chk(s_b_valid === 1'b1 && s_wr_ready === 1'b0, "R10 write blocked while pending",
             {30'b0, s_b_valid, s_wr_ready}, 32'd2);
         tick;
      end
      s_b_ready = 1'b1;
      tick;
      #1;
      chk(s_b_valid === 1'b0 && s_wr_ready === 1'b1, "R6 response taken", {30'b0, s_b_valid, s_wr_ready}, 32'd1);
      tick;
      s_wr_valid = 1'b0; model[5] = 32'h5555_0002;
      tick;
      bus_rd(8'h10, model[4], 2'b00, "R6 first write stored");
      bus_rd(8'h14, model[5], 2'b00, "R10 second write stored");

      summary();
      $finish;
   end
endmodule